// File: doc/BRIEF.md
# Speculation-Aware Snooping Coherence Controller

This block keeps the coherence state of every line in a small snooping cache. Each line holds one word. The protocol starts from MSI and adds two states. The first is a speculative-shared state (Spec), which a line enters when its fill was served while speculative threads held newer data. The second is a modified-clean state (MClean), an exclusive copy that may still be written without bus traffic. The five states and their 3-bit codes are Invalid = 0, Shared = 1, Spec = 2, Modified = 3 and MClean = 4. A line array indexed by `cpu_idx` / `snoop_idx` holds one state per line.

On the local side the processor raises `cpu_req` with a line index and a read/write flag, and holds it until `cpu_done`. A hit completes in the cycle it is accepted. A miss completes a cycle later, in the MISS phase. During that phase the block drives a bus read or read-exclusive command and waits for a fill response. `stall_lo` means no speculative data exists. `stall_hi` means speculative threads hold newer data. `fill_excl` qualifies a low read fill as exclusive.

On the snoop side each accepted snooped read or read-exclusive updates the addressed line in the same cycle. A snoop can have three further effects. It can flag a protocol violation. It can start a supply offer, which stays raised until the external arbiter grants it. It can start a one-cycle writeback before a clean-modified line is dropped.

Top module: `coh_spec_ctrl`

## Requirements
- R1: After reset every line reads Invalid, and `cpu_done`, `bus_cmd`, `supply_cand`, `supply_data`, `wb_req` and `snoop_err` are all 0.
- R2: A local read of a line in Shared, Spec, Modified or MClean raises `cpu_done` in the accepting cycle. It leaves the state unchanged and drives `bus_cmd` = 0 (none).
- R3: A local read of an Invalid line is accepted without `cpu_done`. In the following cycles `bus_cmd` = 1 (read) until a response arrives. On the response the fill completes with `cpu_done`:
  - `stall_hi` gives Spec, even when `stall_lo` is also high.
  - `stall_lo` together with `fill_excl` gives MClean.
  - `stall_lo` alone gives Shared.
- R4: A local write of an Invalid line behaves the same way but drives `bus_cmd` = 2 (read-exclusive). `stall_lo` gives Modified and `stall_hi` gives Spec.
- R5: Local write hits complete in the accepting cycle. Modified stays Modified and MClean becomes Modified, both with `bus_cmd` = 0. Shared becomes Modified with `bus_cmd` = 3 (upgrade). Spec stays Spec with `bus_cmd` = 0.
- R6: A snooped read (`snoop_rdx` = 0) has these effects:
  - Invalid stays Invalid.
  - Spec stays Spec.
  - Shared stays Shared and starts a supply offer.
  - MClean becomes Shared and starts a supply offer.
- R7: A snooped read-exclusive moves Shared and Spec to Invalid. With `snoop_miss` = 1 an MClean line raises `wb_req` for exactly the next cycle, with `wb_idx` set to the line. It becomes Invalid at the end of that cycle.
- R8: `snoop_err` is raised in the snoop cycle in two cases: any snoop that finds Modified, and a read-exclusive with `snoop_miss` = 0 that finds MClean. The line state is left unchanged.
- R9: A supply offer raises `supply_cand` from the cycle after the snoop and holds it until `bus_grant`. `supply_data` is high only in the granted cycle, and `supply_cand` is low in the cycle after the grant.
- R10: `line_excl` is 1 exactly when the line at `cpu_idx` is Modified or MClean.
- R11: A snoop is accepted only while no supply offer or writeback is pending; otherwise it is ignored. A cycle that accepts a snoop accepts no local request, so the local request is served afterwards against the updated state.
- R12: `line_state` reports the state of the line at `cpu_idx` with the codes Invalid = 0, Shared = 1, Spec = 2, Modified = 3, MClean = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Local request, held until `cpu_done` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IDX_W | Line index of the local request and of the state lookup |
| cpu_done | output | 1 | Local request completes this cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 upgrade |
| stall_lo | input | 1 | Fill response, no speculative data held |
| stall_hi | input | 1 | Fill response, speculative threads hold newer data |
| fill_excl | input | 1 | Low read fill is exclusive (fill MClean) |
| snoop_valid | input | 1 | Snooped bus transaction present |
| snoop_rdx | input | 1 | 1 = read-exclusive, 0 = read |
| snoop_miss | input | 1 | Read-exclusive comes from a remote write miss |
| snoop_idx | input | IDX_W | Line index of the snoop |
| snoop_err | output | 1 | Protocol violation seen by the snoop |
| supply_cand | output | 1 | Offer to supply the word, awaiting grant |
| bus_grant | input | 1 | Arbiter grants the supply offer |
| supply_data | output | 1 | Word is driven onto the bus this cycle |
| wb_req | output | 1 | One-cycle writeback request |
| wb_idx | output | IDX_W | Line index of the writeback |
| line_state | output | 3 | State of line `cpu_idx` |
| line_excl | output | 1 | Line `cpu_idx` holds an exclusive copy |

## Verification
The bench sweeps the five states against the five operations: local read, local write, snooped read, read-exclusive from a write hit, and read-exclusive from a write miss. Each starting state is built through the fill path, which also exercises every fill outcome. This separates transitions that share a target state but differ in bus command, error, supply or writeback side effects. Directed patterns add a double fill response, a snoop colliding with a local write on the same line, and a snoop arriving while a supply offer is pending. These separate correct ordering and blocking from a controller that serves the two sides independently.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        LS_INV  = 3'd0,
        LS_SHR  = 3'd1,
        LS_SPEC = 3'd2,
        LS_MOD  = 3'd3,
        LS_MCLN = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_UPG  = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        LC_IDLE = 1'b0,
        LC_MISS = 1'b1
    } lctl_st_e;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
    import coh_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output line_st_e         ra_st,
    input  logic [IDX_W-1:0] rb_idx,
    output line_st_e         rb_st,
    input  logic             pa_en,
    input  logic [IDX_W-1:0] pa_idx,
    input  line_st_e         pa_st,
    input  logic             pb_en,
    input  logic [IDX_W-1:0] pb_idx,
    input  line_st_e         pb_st
);
    localparam int DEPTH = 1 << IDX_W;

    line_st_e lines [DEPTH];

    // Port a (local side) wins a same-line collision.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                lines[i] <= LS_INV;
            end else if (pa_en && pa_idx == IDX_W'(i)) begin
                lines[i] <= pa_st;
            end else if (pb_en && pb_idx == IDX_W'(i)) begin
                lines[i] <= pb_st;
            end
        end
    end

    assign ra_st = lines[ra_idx];
    assign rb_st = lines[rb_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_valid,
    input  logic             snp_rdx,
    input  logic             snp_miss,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_e         snp_cur,
    input  logic             bus_grant,
    output logic             snp_take,
    output logic             busy,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output line_st_e         wr_st,
    output logic             snp_err,
    output logic             supply_cand,
    output logic             supply_data,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx
);
    logic             sup_pend;
    logic             wb_pend;
    logic [IDX_W-1:0] wb_idx_q;
    line_st_e         nxt;
    logic             err;
    logic             want_sup;
    logic             want_wb;

    always_comb begin
        nxt      = snp_cur;
        err      = 1'b0;
        want_sup = 1'b0;
        want_wb  = 1'b0;
        unique case (snp_cur)
            LS_INV:  ;
            LS_SHR: begin
                if (snp_rdx) nxt = LS_INV;
                else         want_sup = 1'b1;
            end
            LS_SPEC: begin
                if (snp_rdx) nxt = LS_INV;
            end
            LS_MOD:  err = 1'b1;
            LS_MCLN: begin
                if (!snp_rdx) begin
                    nxt      = LS_SHR;
                    want_sup = 1'b1;
                end else if (snp_miss) begin
                    want_wb = 1'b1;
                end else begin
                    err = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign busy     = sup_pend | wb_pend;
    assign snp_take = snp_valid && !busy;

    always_comb begin
        if (wb_pend) begin
            wr_en  = 1'b1;
            wr_idx = wb_idx_q;
            wr_st  = LS_INV;
        end else begin
            wr_en  = snp_take && (nxt != snp_cur);
            wr_idx = snp_idx;
            wr_st  = nxt;
        end
    end

    assign snp_err     = snp_take && err;
    assign supply_cand = sup_pend;
    assign supply_data = sup_pend && bus_grant;
    assign wb_req      = wb_pend;
    assign wb_idx      = wb_idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_pend <= 1'b0;
            wb_pend  <= 1'b0;
            wb_idx_q <= '0;
        end else begin
            if (snp_take && want_sup)      sup_pend <= 1'b1;
            else if (sup_pend && bus_grant) sup_pend <= 1'b0;
            wb_pend <= snp_take && want_wb;
            if (snp_take && want_wb) wb_idx_q <= snp_idx;
        end
    end

endmodule

// File: rtl/coh_local_ctrl.sv
module coh_local_ctrl
    import coh_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_write,
    input  logic [IDX_W-1:0] cpu_idx,
    input  line_st_e         cur_st,
    input  logic             blocked,
    input  logic             stall_lo,
    input  logic             stall_hi,
    input  logic             fill_excl,
    output logic             cpu_done,
    output bus_cmd_e         bus_cmd,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output line_st_e         wr_st
);
    lctl_st_e         st_q, st_d;
    logic [IDX_W-1:0] miss_idx_q;
    logic             miss_wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= LC_IDLE;
            miss_idx_q <= '0;
            miss_wr_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == LC_IDLE && st_d == LC_MISS) begin
                miss_idx_q <= cpu_idx;
                miss_wr_q  <= cpu_write;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        cpu_done = 1'b0;
        bus_cmd  = BC_NONE;
        wr_en    = 1'b0;
        wr_idx   = cpu_idx;
        wr_st    = cur_st;
        unique case (st_q)
            LC_IDLE: begin
                if (cpu_req && !blocked) begin
                    if (cur_st == LS_INV) begin
                        st_d = LC_MISS;
                    end else begin
                        cpu_done = 1'b1;
                        if (cpu_write) begin
                            if (cur_st == LS_SHR) begin
                                wr_en   = 1'b1;
                                wr_st   = LS_MOD;
                                bus_cmd = BC_UPG;
                            end else if (cur_st == LS_MCLN) begin
                                wr_en = 1'b1;
                                wr_st = LS_MOD;
                            end
                        end
                    end
                end
            end
            LC_MISS: begin
                bus_cmd = miss_wr_q ? BC_RDX : BC_RD;
                wr_idx  = miss_idx_q;
                if (stall_hi || stall_lo) begin
                    cpu_done = 1'b1;
                    wr_en    = 1'b1;
                    st_d     = LC_IDLE;
                    if (stall_hi)       wr_st = LS_SPEC;
                    else if (miss_wr_q) wr_st = LS_MOD;
                    else if (fill_excl) wr_st = LS_MCLN;
                    else                wr_st = LS_SHR;
                end
            end
            default: st_d = LC_IDLE;
        endcase
    end

endmodule

// File: rtl/coh_spec_ctrl.sv
module coh_spec_ctrl
    import coh_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_write,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_done,
    output logic [1:0]       bus_cmd,
    input  logic             stall_lo,
    input  logic             stall_hi,
    input  logic             fill_excl,
    input  logic             snoop_valid,
    input  logic             snoop_rdx,
    input  logic             snoop_miss,
    input  logic [IDX_W-1:0] snoop_idx,
    output logic             snoop_err,
    output logic             supply_cand,
    input  logic             bus_grant,
    output logic             supply_data,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx,
    output logic [2:0]       line_state,
    output logic             line_excl
);
    line_st_e         cpu_st;
    line_st_e         snp_st;
    logic             snp_take;
    logic             snp_busy;
    logic             lc_wr_en;
    logic [IDX_W-1:0] lc_wr_idx;
    line_st_e         lc_wr_st;
    logic             sn_wr_en;
    logic [IDX_W-1:0] sn_wr_idx;
    line_st_e         sn_wr_st;
    bus_cmd_e         lc_cmd;

    coh_line_array #(.IDX_W(IDX_W)) u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (cpu_idx),
        .ra_st  (cpu_st),
        .rb_idx (snoop_idx),
        .rb_st  (snp_st),
        .pa_en  (lc_wr_en),
        .pa_idx (lc_wr_idx),
        .pa_st  (lc_wr_st),
        .pb_en  (sn_wr_en),
        .pb_idx (sn_wr_idx),
        .pb_st  (sn_wr_st)
    );

    coh_snoop_unit #(.IDX_W(IDX_W)) u_snoop (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_valid   (snoop_valid),
        .snp_rdx     (snoop_rdx),
        .snp_miss    (snoop_miss),
        .snp_idx     (snoop_idx),
        .snp_cur     (snp_st),
        .bus_grant   (bus_grant),
        .snp_take    (snp_take),
        .busy        (snp_busy),
        .wr_en       (sn_wr_en),
        .wr_idx      (sn_wr_idx),
        .wr_st       (sn_wr_st),
        .snp_err     (snoop_err),
        .supply_cand (supply_cand),
        .supply_data (supply_data),
        .wb_req      (wb_req),
        .wb_idx      (wb_idx)
    );

    coh_local_ctrl #(.IDX_W(IDX_W)) u_local (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_write (cpu_write),
        .cpu_idx   (cpu_idx),
        .cur_st    (cpu_st),
        .blocked   (snp_take | snp_busy),
        .stall_lo  (stall_lo),
        .stall_hi  (stall_hi),
        .fill_excl (fill_excl),
        .cpu_done  (cpu_done),
        .bus_cmd   (lc_cmd),
        .wr_en     (lc_wr_en),
        .wr_idx    (lc_wr_idx),
        .wr_st     (lc_wr_st)
    );

    assign bus_cmd    = lc_cmd;
    assign line_state = cpu_st;
    assign line_excl  = (cpu_st == LS_MOD) || (cpu_st == LS_MCLN);

endmodule

// File: rtl/coh_ctl_chk.sv
module coh_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_write,
    input logic       cpu_done,
    input logic [1:0] bus_cmd,
    input logic       snoop_valid,
    input logic       snoop_rdx,
    input logic       snoop_miss,
    input logic       bus_grant,
    input logic       supply_cand,
    input logic       supply_data,
    input logic       wb_req,
    input logic [2:0] line_state
);
    p_rdhit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && !cpu_write && line_state != 3'd0) |-> bus_cmd == 2'd0);

    p_upg_only_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd3) |-> (cpu_done && cpu_write && line_state == 3'd1));

    p_wb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |=> !wb_req);

    p_wb_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_req) |-> $past(snoop_valid && snoop_rdx && snoop_miss));

    p_supply_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        supply_data |-> (bus_grant && supply_cand));

    p_cand_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_cand && !bus_grant) |=> supply_cand);

    p_cand_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        supply_data |=> !supply_cand);

    p_state_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        line_state <= 3'd4);
endmodule

bind coh_spec_ctrl coh_ctl_chk u_chk (.*);

// File: tb/sim_coh_spec_ctrl.sv
module sim_coh_spec_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic cpu_req, cpu_write, stall_lo, stall_hi, fill_excl;
    logic [IDX_W-1:0] cpu_idx, snoop_idx;
    logic snoop_valid, snoop_rdx, snoop_miss, bus_grant;
    logic cpu_done, snoop_err, supply_cand, supply_data, wb_req, line_excl;
    logic [1:0] bus_cmd;
    logic [2:0] line_state;
    logic [IDX_W-1:0] wb_idx;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_spec_ctrl #(.IDX_W(IDX_W)) u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_req = 0; cpu_write = 0; cpu_idx = '0; stall_lo = 0; stall_hi = 0;
        fill_excl = 0; snoop_valid = 0; snoop_rdx = 0; snoop_miss = 0;
        snoop_idx = '0; bus_grant = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic probe(input int idx, output int st, output int ex);
        @(negedge clk);
        cpu_req = 0;
        cpu_idx = IDX_W'(idx);
        #1;
        st = int'(line_state);
        ex = int'(line_excl);
    endtask

    task automatic local_op(input int idx, input bit wr, input bit lo, input bit hi,
                            input bit ex, output int cmd_seen, output int cyc);
        @(negedge clk);
        cpu_req = 1; cpu_write = wr; cpu_idx = IDX_W'(idx);
        stall_lo = lo; stall_hi = hi; fill_excl = ex;
        cmd_seen = 0; cyc = 0;
        for (int k = 0; k < 6; k++) begin
            #1;
            if (bus_cmd != 2'd0) cmd_seen = int'(bus_cmd);
            cyc++;
            if (cpu_done) break;
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 0; stall_lo = 0; stall_hi = 0; fill_excl = 0;
    endtask

    task automatic make_state(input int idx, input int st);
        int c, n;
        case (st)
            1: local_op(idx, 0, 1, 0, 0, c, n);
            2: local_op(idx, 0, 0, 1, 0, c, n);
            3: local_op(idx, 1, 1, 0, 0, c, n);
            4: local_op(idx, 0, 1, 0, 1, c, n);
            default: ;
        endcase
    endtask

    function automatic int exp_state(input int s, input int op);
        case (op)
            0: return (s == 0) ? 1 : s;
            1: return (s == 2) ? 2 : 3;
            2: return (s == 4) ? 1 : s;
            3: return (s == 1 || s == 2) ? 0 : s;
            default: return (s == 1 || s == 2 || s == 4) ? 0 : s;
        endcase
    endfunction

    function automatic int exp_cmd(input int s, input int op);
        if (op == 0) return (s == 0) ? 1 : 0;
        if (op == 1) return (s == 0) ? 2 : (s == 1) ? 3 : 0;
        return 0;
    endfunction

    function automatic int exp_err(input int s, input int op);
        if (op < 2) return 0;
        if (s == 3) return 1;
        return (op == 3 && s == 4) ? 1 : 0;
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int st, ex, cmd, cyc, err, cand, wb, widx;
        do_reset();

        // R1: reset state
        for (int i = 0; i < (1 << IDX_W); i++) begin
            probe(i, st, ex);
            check(st == 0, "R1 line invalid", st, 0);
        end
        #1;
        check({cpu_done, bus_cmd, supply_cand, supply_data, wb_req, snoop_err} == 0,
              "R1 outputs idle", int'({cpu_done, bus_cmd, supply_cand, supply_data, wb_req, snoop_err}), 0);

        // Sweep: five states x five operations
        for (int s = 0; s < 5; s++) begin
            for (int op = 0; op < 5; op++) begin
                do_reset();
                make_state(2, s);
                probe(2, st, ex);
                check(st == s, "R12 state code after build (R3 R4 fills)", st, s);
                check(ex == ((s == 3 || s == 4) ? 1 : 0), "R10 exclusive flag", ex, (s == 3 || s == 4) ? 1 : 0);
                if (op < 2) begin
                    local_op(2, op[0], 1, 0, 0, cmd, cyc);
                    check(cmd == exp_cmd(s, op), op == 0 ? "R2 R3 bus command" : "R4 R5 bus command",
                          cmd, exp_cmd(s, op));
                    check(cyc == ((s == 0) ? 2 : 1), "R2 R5 completion cycle", cyc, (s == 0) ? 2 : 1);
                end else begin
                    @(negedge clk);
                    snoop_valid = 1; snoop_idx = 3'd2;
                    snoop_rdx = (op != 2); snoop_miss = (op == 4);
                    #1;
                    err = int'(snoop_err);
                    check(err == exp_err(s, op), "R8 snoop error", err, exp_err(s, op));
                    @(negedge clk);
                    snoop_valid = 0; snoop_rdx = 0; snoop_miss = 0;
                    #1;
                    cand = int'(supply_cand);
                    wb = int'(wb_req);
                    widx = int'(wb_idx);
                    check(cand == ((op == 2 && (s == 1 || s == 4)) ? 1 : 0), "R6 supply offer",
                          cand, (op == 2 && (s == 1 || s == 4)) ? 1 : 0);
                    check(wb == ((op == 4 && s == 4) ? 1 : 0), "R7 writeback request",
                          wb, (op == 4 && s == 4) ? 1 : 0);
                    if (wb == 1) begin
                        check(widx == 2, "R7 writeback index", widx, 2);
                        @(negedge clk);
                        #1;
                        check(wb_req == 1'b0, "R7 writeback one cycle", int'(wb_req), 0);
                    end
                    if (cand == 1) begin
                        @(negedge clk);
                        #1;
                        check(supply_cand && !supply_data, "R9 offer held without grant",
                              int'({supply_cand, supply_data}), 2);
                        bus_grant = 1;
                        #1;
                        check(supply_data == 1'b1, "R9 data on grant", int'(supply_data), 1);
                        @(negedge clk);
                        bus_grant = 0;
                        #1;
                        check(supply_cand == 1'b0, "R9 offer dropped after grant", int'(supply_cand), 0);
                    end
                end
                probe(2, st, ex);
                check(st == exp_state(s, op), "R2-sweep next state R5 R6 R7", st, exp_state(s, op));
            end
        end

        // R3: both fill responses -> Spec
        do_reset();
        local_op(1, 0, 1, 1, 0, cmd, cyc);
        probe(1, st, ex);
        check(st == 2, "R3 double response gives Spec", st, 2);
        // R4: write miss with high response -> Spec
        local_op(4, 1, 0, 1, 0, cmd, cyc);
        probe(4, st, ex);
        check(st == 2 && cmd == 2, "R4 write miss high fill", st * 4 + cmd, 10);

        // R11: snoop and local write on the same line in one cycle
        do_reset();
        make_state(5, 1);
        @(negedge clk);
        cpu_req = 1; cpu_write = 1; cpu_idx = 3'd5; stall_lo = 1;
        snoop_valid = 1; snoop_rdx = 1; snoop_miss = 0; snoop_idx = 3'd5;
        #1;
        check(cpu_done == 1'b0 && bus_cmd == 2'd0, "R11 local held in snoop cycle",
              int'({cpu_done, bus_cmd}), 0);
        @(negedge clk);
        snoop_valid = 0; snoop_rdx = 0;
        cmd = 0;
        for (int k = 0; k < 4; k++) begin
            #1;
            if (bus_cmd != 2'd0) cmd = int'(bus_cmd);
            if (cpu_done) break;
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 0; stall_lo = 0; cpu_write = 0;
        check(cmd == 2, "R11 local served as miss after snoop", cmd, 2);
        probe(5, st, ex);
        check(st == 3, "R11 final state Modified", st, 3);

        // R11: snoop ignored while a supply offer is pending
        do_reset();
        make_state(6, 1);
        @(negedge clk);
        snoop_valid = 1; snoop_rdx = 0; snoop_idx = 3'd6;
        @(negedge clk);
        snoop_rdx = 1; snoop_miss = 0;
        #1;
        check(supply_cand == 1'b1, "R11 offer pending", int'(supply_cand), 1);
        @(negedge clk);
        snoop_valid = 0; snoop_rdx = 0;
        probe(6, st, ex);
        check(st == 1, "R11 ignored snoop leaves Shared", st, 1);
        @(negedge clk);
        bus_grant = 1;
        #1;
        check(supply_data == 1'b1, "R9 late grant supplies", int'(supply_data), 1);
        @(negedge clk);
        bus_grant = 0;

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule